// File: doc/BRIEF.md
# Watchdog Timer with Selectable Clear Discipline

This block guards a processor core against runaway code. A counter advances on one of two time sources, picked by a static option. One source is a free-running tick from a dedicated internal oscillator. The other is the instruction rate, which is the system clock divided by four. If software fails to service the counter before it wraps after 2^CNT_W ticks, the block raises a reset request.

What that request is depends on the core's state. A running core receives a full-chip reset request and a sticky time-out flag is set. A halted core receives only a warm-reset request, which restores just its program counter and stack pointer, and the flag is left alone. When the instruction-rate source is selected and the core is halted, that source stops ticking, so the counter freezes.

Software services the watchdog in one of two disciplines, chosen by a static option. In single mode, one clear command suffices. In paired mode, two distinct commands must both be seen, in either order, before the counter clears. A low level on the external reset input and a halt-instruction pulse also clear the counter.

Top module: `wdt_dual_clear`

## Requirements
- R1: With the oscillator source selected (`sel_instr`=0) and `osc_tick` high every cycle, a counter cleared at clock edge E raises an overflow request on the edge E+2^CNT_W. No request is raised before that edge.
- R2: With the instruction source selected (`sel_instr`=1) and the core running, the counter advances once every 4 clock cycles. An overflow request therefore follows a clear by between 4·2^CNT_W−3 and 4·2^CNT_W clock edges.
- R3: With the instruction source selected and `halted`=1, the counter does not advance and no request of either kind is raised. After `halted` falls, counting resumes from the value held.
- R4: An overflow while `halted`=0 asserts `chip_rst_req` and sets `timeout_flag` on the same edge. After reset, all three outputs are 0.
- R5: An overflow while `halted`=1 asserts `warm_rst_req` only. `chip_rst_req` stays 0.
- R6: `ext_rst_n`=0 clears the counter and `timeout_flag`. A `halt_insn` pulse clears the counter. In both cases the next overflow comes 2^CNT_W ticks after that clear.
- R7: In single mode (`dual_clear`=0), a `clr_single` pulse clears the counter. Pulses on `clr_first` or `clr_second` do not change the overflow time.
- R8: In paired mode (`dual_clear`=1), the counter clears on the edge where both `clr_first` and `clr_second` have been seen since the last clear, in either order or in the same cycle. A single pulse of one of them, repeated pulses of one of them, or `clr_single` do not change the overflow time.
- R9: A paired command recorded before an overflow is forgotten at the overflow. It does not combine with the other paired command issued afterwards.
- R10: `timeout_flag` stays set through a warm-reset request. It clears on a `flag_clr` pulse. If an overflow and `flag_clr` fall on the same edge, the flag ends set.
- R11: Each request is high for exactly one cycle. The counter restarts from zero at the overflow, so the next overflow follows 2^CNT_W ticks later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| osc_tick | input | 1 | One-cycle tick from the internal watchdog oscillator |
| sel_instr | input | 1 | Source option: 0 = oscillator tick, 1 = instruction rate (clk/4) |
| dual_clear | input | 1 | Clear option: 0 = single command, 1 = paired commands |
| clr_single | input | 1 | Decoded single clear command pulse |
| clr_first | input | 1 | Decoded first paired clear command pulse |
| clr_second | input | 1 | Decoded second paired clear command pulse |
| halt_insn | input | 1 | Halt-instruction pulse; clears the counter |
| halted | input | 1 | Level, high while the core is halted |
| ext_rst_n | input | 1 | Active-low external reset; clears counter and flag |
| flag_clr | input | 1 | Clears the time-out flag |
| chip_rst_req | output | 1 | One-cycle full-chip reset request |
| warm_rst_req | output | 1 | One-cycle warm-reset request |
| timeout_flag | output | 1 | Sticky time-out status |

## Verification
The embedded assertions check properties that must hold on every cycle:
- the two requests never coincide, and each lasts one cycle;
- a full request always carries the flag with it;
- a warm request never drops a set flag;
- a frozen instruction source never produces a request;
- an external reset always leaves the flag clear;
- no paired command is recorded in single mode.

Only the bench scenarios can show the exact overflow edge after each clear. Those scenarios cover the single and paired disciplines with commands in different orders, which commands are ignored, forgetting a half-complete pair at an overflow, the divided instruction rate, and which of `flag_clr` and an overflow wins on the same edge.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic {
        SRC_OSC   = 1'b0,
        SRC_INSTR = 1'b1
    } wdt_src_e;

    typedef enum logic {
        DISC_SINGLE = 1'b0,
        DISC_PAIRED = 1'b1
    } wdt_disc_e;

    typedef struct packed {
        logic single;
        logic first;
        logic second;
    } wdt_cmd_t;

    typedef struct packed {
        logic chip;
        logic warm;
    } wdt_req_t;

    function automatic wdt_req_t route_overflow(input logic ovf, input logic core_halted);
        wdt_req_t r;
        r.chip = ovf && !core_halted;
        r.warm = ovf && core_halted;
        return r;
    endfunction

endpackage

// File: rtl/wdt_tick_sel.sv
module wdt_tick_sel
    import wdt_pkg::*;
#(
    parameter int INSTR_DIV = 4
) (
    input  logic     clk,
    input  logic     rst,
    input  wdt_src_e src,
    input  logic     osc_tick,
    input  logic     halted,
    output logic     tick
);
    localparam int DIV_W = (INSTR_DIV > 2) ? $clog2(INSTR_DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(INSTR_DIV - 1);

    logic [DIV_W-1:0] div_q;
    logic             instr_tick;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0;
        end else if (div_q == DIV_LAST) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    // the instruction clock is gated off while the core is halted
    assign instr_tick = (div_q == DIV_LAST) && !halted;

    always_comb begin
        if (src == SRC_INSTR) tick = instr_tick;
        else                  tick = osc_tick;
    end

endmodule

// File: rtl/wdt_clear_ctl.sv
module wdt_clear_ctl
    import wdt_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  wdt_disc_e disc,
    input  wdt_cmd_t  cmd,
    input  logic      hard_clr,
    input  logic      ovf,
    output logic      sw_clr
);
    logic seen_first_q;
    logic seen_second_q;
    logic have_first;
    logic have_second;

    assign have_first  = seen_first_q  || cmd.first;
    assign have_second = seen_second_q || cmd.second;

    always_comb begin
        if (disc == DISC_PAIRED) sw_clr = have_first && have_second;
        else                     sw_clr = cmd.single;
    end

    always_ff @(posedge clk) begin
        if (rst || hard_clr || sw_clr || ovf) begin
            seen_first_q  <= 1'b0;
            seen_second_q <= 1'b0;
        end else if (disc == DISC_PAIRED) begin
            seen_first_q  <= have_first;
            seen_second_q <= have_second;
        end
    end

    AST_SEEN_ONLY_PAIRED: assert property (@(posedge clk) disable iff (rst)
        (disc == DISC_SINGLE && $past(disc == DISC_SINGLE)) |-> (!seen_first_q && !seen_second_q)); // R7

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
    parameter int CNT_W = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic clr,
    output logic ovf
);
    localparam logic [CNT_W-1:0] CNT_LAST = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;

    // a clear outranks the tick that would have wrapped the counter
    assign ovf = tick && !clr && (cnt_q == CNT_LAST);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
        ovf |=> (cnt_q == '0)); // R11

endmodule

// File: rtl/wdt_dual_clear.sv
module wdt_dual_clear
    import wdt_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int INSTR_DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic osc_tick,
    input  logic sel_instr,
    input  logic dual_clear,
    input  logic clr_single,
    input  logic clr_first,
    input  logic clr_second,
    input  logic halt_insn,
    input  logic halted,
    input  logic ext_rst_n,
    input  logic flag_clr,
    output logic chip_rst_req,
    output logic warm_rst_req,
    output logic timeout_flag
);
    wdt_src_e  src;
    wdt_disc_e disc;
    wdt_cmd_t  cmd;
    wdt_req_t  req_next;
    logic      tick;
    logic      hard_clr;
    logic      sw_clr;
    logic      ovf;

    assign src      = wdt_src_e'(sel_instr);
    assign disc     = wdt_disc_e'(dual_clear);
    assign cmd      = '{single: clr_single, first: clr_first, second: clr_second};
    assign hard_clr = !ext_rst_n || halt_insn;

    wdt_tick_sel #(.INSTR_DIV(INSTR_DIV)) u_tick (
        .clk      (clk),
        .rst      (rst),
        .src      (src),
        .osc_tick (osc_tick),
        .halted   (halted),
        .tick     (tick)
    );

    wdt_clear_ctl u_clr (
        .clk      (clk),
        .rst      (rst),
        .disc     (disc),
        .cmd      (cmd),
        .hard_clr (hard_clr),
        .ovf      (ovf),
        .sw_clr   (sw_clr)
    );

    wdt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .tick (tick),
        .clr  (hard_clr || sw_clr),
        .ovf  (ovf)
    );

    assign req_next = route_overflow(ovf, halted);

    always_ff @(posedge clk) begin
        if (rst) begin
            chip_rst_req <= 1'b0;
            warm_rst_req <= 1'b0;
            timeout_flag <= 1'b0;
        end else begin
            chip_rst_req <= req_next.chip;
            warm_rst_req <= req_next.warm;
            if (req_next.chip)               timeout_flag <= 1'b1;
            else if (!ext_rst_n || flag_clr) timeout_flag <= 1'b0;
        end
    end

    AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(chip_rst_req && warm_rst_req)); // R5
    AST_CHIP_PULSE: assert property (@(posedge clk) disable iff (rst)
        chip_rst_req |=> !chip_rst_req); // R11
    AST_WARM_PULSE: assert property (@(posedge clk) disable iff (rst)
        warm_rst_req |=> !warm_rst_req); // R11
    AST_CHIP_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
        chip_rst_req |-> timeout_flag); // R4
    AST_WARM_KEEPS_FLAG: assert property (@(posedge clk) disable iff (rst)
        (warm_rst_req && $past(timeout_flag && ext_rst_n && !flag_clr)) |-> timeout_flag); // R10
    AST_EXT_CLEARS_FLAG: assert property (@(posedge clk) disable iff (rst)
        !ext_rst_n |=> !timeout_flag); // R6
    AST_FROZEN_NO_REQ: assert property (@(posedge clk) disable iff (rst)
        (sel_instr && halted && $past(sel_instr && halted)) |-> (!chip_rst_req && !warm_rst_req)); // R3

endmodule

// File: tb/wdt_dual_clear_tb.sv
module wdt_dual_clear_tb;
    localparam int W    = 8;
    localparam int M    = 1 << W;
    localparam int NVEC = 8;

    // {dual, cmd1, edge1, cmd2, edge2, expected overflow edge}; cmd: 0 none 1 single 2 first 3 second
    localparam logic [34:0] VEC [NVEC] = '{
        {1'b0, 2'd1, 10'd50, 2'd0, 10'd0,  10'd306},   // R7 single clears
        {1'b0, 2'd2, 10'd50, 2'd3, 10'd60, 10'd256},   // R7 paired ignored
        {1'b1, 2'd2, 10'd50, 2'd3, 10'd80, 10'd336},   // R8 first then second
        {1'b1, 2'd3, 10'd40, 2'd2, 10'd90, 10'd346},   // R8 second then first
        {1'b1, 2'd1, 10'd50, 2'd0, 10'd0,  10'd256},   // R8 single ignored
        {1'b1, 2'd2, 10'd50, 2'd2, 10'd70, 10'd256},   // R8 one command twice
        {1'b1, 2'd2, 10'd60, 2'd3, 10'd60, 10'd316},   // R8 same cycle
        {1'b0, 2'd0, 10'd0,  2'd0, 10'd0,  10'd256}    // R1 untouched
    };

    logic clk = 0, rst = 1;
    logic osc_tick = 1, sel_instr = 0, dual_clear = 0;
    logic clr_single = 0, clr_first = 0, clr_second = 0;
    logic halt_insn = 0, halted = 0, ext_rst_n = 1, flag_clr = 0;
    logic chip_rst_req, warm_rst_req, timeout_flag;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    wdt_dual_clear #(.CNT_W(W), .INSTR_DIV(4)) u_dut (
        .clk(clk), .rst(rst), .osc_tick(osc_tick), .sel_instr(sel_instr),
        .dual_clear(dual_clear), .clr_single(clr_single), .clr_first(clr_first),
        .clr_second(clr_second), .halt_insn(halt_insn), .halted(halted),
        .ext_rst_n(ext_rst_n), .flag_clr(flag_clr), .chip_rst_req(chip_rst_req),
        .warm_rst_req(warm_rst_req), .timeout_flag(timeout_flag)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic hclear();
        halt_insn = 1;
        @(negedge clk);
        halt_insn = 0;
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // counts edges after the current negedge until the chosen request is seen
    task automatic wait_req(input bit warm, input int maxk, output int k);
        k = 0;
        for (int j = 1; j <= maxk; j++) begin
            @(negedge clk);
            if ((warm ? warm_rst_req : chip_rst_req) && k == 0) begin
                k = j;
                break;
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int k, k2;
        step(3);
        rst = 0;
        check(!chip_rst_req && !warm_rst_req && !timeout_flag, "R4 reset state",
              {chip_rst_req, warm_rst_req, timeout_flag}, 0);

        // vector table
        for (int i = 0; i < NVEC; i++) begin
            logic [34:0] v;
            logic [1:0] c1, c2;
            int t1, t2, ex, got;
            v = VEC[i];
            dual_clear = v[34];
            c1 = v[33:32]; t1 = int'(v[31:22]);
            c2 = v[21:20]; t2 = int'(v[19:10]);
            ex = int'(v[9:0]);
            hclear();
            got = 0;
            for (int j = 1; j <= 600; j++) begin
                clr_single = (c1 == 2'd1 && t1 == j) || (c2 == 2'd1 && t2 == j);
                clr_first  = (c1 == 2'd2 && t1 == j) || (c2 == 2'd2 && t2 == j);
                clr_second = (c1 == 2'd3 && t1 == j) || (c2 == 2'd3 && t2 == j);
                @(negedge clk);
                if (chip_rst_req) begin
                    got = j;
                    break;
                end
            end
            clr_single = 0; clr_first = 0; clr_second = 0;
            check(got == ex, $sformatf("R8/R7/R1 vector %0d overflow edge", i), got, ex);
            check(timeout_flag == 1'b1, "R4 flag set by overflow", timeout_flag, 1);
        end
        dual_clear = 0;

        // R11: one-cycle pulse and restart from zero
        hclear();
        wait_req(0, 600, k);
        check(k == M, "R1 first overflow edge", k, M);
        step(1);
        check(!chip_rst_req, "R11 request lasts one cycle", chip_rst_req, 0);
        wait_req(0, 600, k2);
        check(k2 == M - 1, "R11 next overflow after restart", k2 + 1, M);

        // R10: flag_clr clears; set wins over clear on same edge
        step(1);
        flag_clr = 1; step(1); flag_clr = 0;
        check(!timeout_flag, "R10 flag_clr clears flag", timeout_flag, 0);
        hclear();
        step(M - 1);
        flag_clr = 1; step(1); flag_clr = 0;
        check(chip_rst_req && timeout_flag, "R10 overflow beats flag_clr",
              {chip_rst_req, timeout_flag}, 3);

        // R5: halted overflow gives warm request only, flag kept
        halted = 1;
        hclear();
        wait_req(1, 600, k);
        check(k == M, "R5 warm request edge", k, M);
        check(!chip_rst_req, "R5 no chip request when halted", chip_rst_req, 0);
        check(timeout_flag, "R10 flag survives warm reset", timeout_flag, 1);
        halted = 0;

        // R6: external reset clears flag and counter
        step(100);
        ext_rst_n = 0; step(1); ext_rst_n = 1;
        check(!timeout_flag, "R6 external reset clears flag", timeout_flag, 0);
        wait_req(0, 600, k);
        check(k == M, "R6 overflow after external reset", k, M);

        // R9: half pair forgotten at overflow
        dual_clear = 1;
        hclear();
        step(99);
        clr_first = 1; step(1); clr_first = 0;
        wait_req(0, 600, k);
        check(k == M - 100, "R9 half pair does not clear", k + 100, M);
        step(43);
        clr_second = 1; step(1); clr_second = 0;
        wait_req(0, 600, k2);
        check(k2 == M - 44, "R9 stale first command forgotten", k2 + 44, M);
        dual_clear = 0;

        // R2: instruction-rate source
        sel_instr = 1;
        hclear();
        wait_req(0, 5000, k);
        check(k >= 4 * M - 3 && k <= 4 * M, "R2 instruction-rate overflow", k, 4 * M);

        // R3: halted with instruction source freezes
        step(2);
        halted = 1;
        hclear();
        k = 0;
        for (int j = 0; j < 1500; j++) begin
            @(negedge clk);
            if (chip_rst_req || warm_rst_req) k++;
        end
        check(k == 0, "R3 no request while frozen", k, 0);
        halted = 0;
        wait_req(0, 5000, k);
        check(k >= 4 * M - 3 && k <= 4 * M, "R3 resumes from held value", k, 4 * M);
        sel_instr = 0;

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule